// File: doc/BRIEF.md
# Interrupt Enable and Synchronizer

This block is the front end between a periodic interval timer and a processor's interrupt input. The timer emits a short request pulse about once per millisecond. Software arms or disarms interrupt delivery through two register-access strobes. A write strobe sets an enable latch and a read strobe clears it. On each rising edge of the timer request, a request register takes a copy of the enable latch. A second register carries that request across to the processor's instruction-fetch timing: it loads on each rising edge of the fetch-start strobe.

The processor sees an active-low interrupt line. That line is low only when three things are high together: the fetch-start strobe level, the re-timed request and the captured request. When the processor acknowledges, both request registers are emptied.

The timer request and the fetch strobe are asynchronous to the system clock. Each passes through a two-stage synchronizer and a single-cycle rising-edge detector, and all state runs on `clk_i`. The register strobes and the acknowledge are synchronous single-clock qualifiers.

Top module: `intr_front_end`

## Requirements
- R1: While `rst_ni` is low and after it is released, with no stimulus, the enable latch, the request register and the sync register are all 0 and `irq_no` is 1.
- R2: A cycle with `en_wr_i`=1 and `en_rd_i`=0 sets the enable latch from the next clock edge onward.
- R3: A cycle with `en_rd_i`=1 clears the enable latch from the next clock edge onward.
- R4: When `en_wr_i` and `en_rd_i` are both 1 in the same cycle, the enable latch ends up cleared.
- R5: On each detected rising edge of `tick_i`, the request register loads the current enable latch value. It becomes 1 if the latch is set and 0 if it is clear.
- R6: On each detected rising edge of `fetch_i`, the sync register loads the current request register value.
- R7: `irq_no` = NOT(synchronized `fetch_i` level AND sync register AND request register). It is low only when all three are 1.
- R8: `ack_i`=1 clears both the request and the sync registers at the next edge. This takes priority over a request or fetch edge detected in the same cycle.
- R9: `tick_i` and `fetch_i` each pass through `SYNC_STAGES` (default 2) flip-flops before edge detection. With the default depth, an input rise first present at clock edge k acts on the registers at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| en_wr_i | input | 1 | Decoded write strobe of the enable register (sets latch) |
| en_rd_i | input | 1 | Decoded read strobe of the enable register (clears latch) |
| tick_i | input | 1 | Periodic request pulse from the timer, asynchronous |
| fetch_i | input | 1 | Instruction-fetch start strobe, asynchronous |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| irq_no | output | 1 | Active-low interrupt to the processor |

## Verification
The assertions take `en_wr_i`, `en_rd_i` and `ack_i` to be synchronous to `clk_i` and sampled once per edge. They also take the synchronized strobes to be the only route by which `tick_i` and `fetch_i` reach the state. The bench drives every input on the falling clock edge, so each asynchronous input is seen cleanly by the first synchronizer stage. Timer and fetch pulses are held for several cycles, which lets the bench's cycle model predict the exact edge at which each edge detector fires. Random stimulus keeps acknowledge and the register strobes sparse, so that armed requests reach the output between them.

// File: rtl/intr_fe_pkg.sv
package intr_fe_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic lvl;
    logic rise;
  } strobe_t;
endpackage

// File: rtl/intr_sync_edge.sv
module intr_sync_edge
  import intr_fe_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    async_i,
  output strobe_t strb_o
);
  localparam int unsigned TOP = STAGES - 1;

  // sh[0] first capture, sh[TOP] synced level, sh[STAGES] one-cycle delay
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign strb_o.lvl  = sh_q[TOP];
  assign strb_o.rise = sh_q[TOP] & ~sh_q[STAGES];
endmodule

// File: rtl/intr_en_latch.sv
module intr_en_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_o <= 1'b0;
    else if (clr_i)  en_o <= 1'b0;  // clear wins over set
    else if (set_i)  en_o <= 1'b1;
  end
endmodule

// File: rtl/intr_req_pipe.sv
module intr_req_pipe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_rise_i,
  input  logic fetch_rise_i,
  input  logic ack_i,
  output logic req_o,
  output logic sync_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      sync_o <= 1'b0;
    end else if (ack_i) begin
      req_o  <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      if (tick_rise_i)  req_o  <= en_i;
      if (fetch_rise_i) sync_o <= req_o;
    end
  end
endmodule

// File: rtl/intr_front_end.sv
module intr_front_end
  import intr_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_wr_i,
  input  logic en_rd_i,
  input  logic tick_i,
  input  logic fetch_i,
  input  logic ack_i,
  output logic irq_no
);
  localparam int unsigned N_STRB = 2;
  localparam int unsigned IDX_TICK  = 0;
  localparam int unsigned IDX_FETCH = 1;

  logic [N_STRB-1:0] strb_in;
  strobe_t           strb [N_STRB];
  logic              en_q, req_q, sync_q;
  logic              tick_rise, fetch_rise, fetch_lvl;

  assign strb_in[IDX_TICK]  = tick_i;
  assign strb_in[IDX_FETCH] = fetch_i;

  for (genvar g = 0; g < N_STRB; g++) begin : g_sync
    intr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(strb_in[g]),
      .strb_o (strb[g])
    );
  end

  assign tick_rise  = strb[IDX_TICK].rise;
  assign fetch_rise = strb[IDX_FETCH].rise;
  assign fetch_lvl  = strb[IDX_FETCH].lvl;

  intr_en_latch u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (en_wr_i),
    .clr_i (en_rd_i),
    .en_o  (en_q)
  );

  intr_req_pipe u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .tick_rise_i (tick_rise),
    .fetch_rise_i(fetch_rise),
    .ack_i       (ack_i),
    .req_o       (req_q),
    .sync_o      (sync_q)
  );

  assign irq_no = ~(fetch_lvl & sync_q & req_q);
endmodule

// File: rtl/intr_front_end_chk.sv
module intr_front_end_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_wr_i,
  input logic en_rd_i,
  input logic ack_i,
  input logic en_q,
  input logic req_q,
  input logic sync_q,
  input logic tick_rise,
  input logic fetch_rise
);
  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_rd_i) |=> en_q);
  // R3
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rd_i |=> !en_q);
  // R4
  en_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && en_rd_i) |=> !en_q);
  // R5
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> ($past(tick_rise) && $past(en_q) && !$past(ack_i)));
  // R6
  sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> ($past(fetch_rise) && $past(req_q)));
  // R8
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (!req_q && !sync_q));
endmodule

bind intr_front_end intr_front_end_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_wr_i   (en_wr_i),
  .en_rd_i   (en_rd_i),
  .ack_i     (ack_i),
  .en_q      (en_q),
  .req_q     (req_q),
  .sync_q    (sync_q),
  .tick_rise (tick_rise),
  .fetch_rise(fetch_rise)
);

// File: tb/tb_intr_front_end.sv
`timescale 1ns/1ps
module tb_intr_front_end;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, tick = 1'b0, fetch = 1'b0, ack = 1'b0;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side cycle model: m_t/m_f[0..1] synchronizer, [2] delay
  logic [2:0] m_t = '0, m_f = '0;
  logic m_en = 1'b0, m_req = 1'b0, m_sy = 1'b0;

  always #5 clk = ~clk;

  intr_front_end dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_wr_i(wr),
    .en_rd_i(rd),
    .tick_i (tick),
    .fetch_i(fetch),
    .ack_i  (ack),
    .irq_no (irq_n)
  );

  function automatic logic exp_irq_n(input logic f_lvl, input logic sy, input logic rq);
    return ~(f_lvl & sy & rq);
  endfunction

  task automatic model_edge();
    logic t_rise, f_rise, en_n, req_n, sy_n;
    t_rise = m_t[1] & ~m_t[2];
    f_rise = m_f[1] & ~m_f[2];
    en_n  = rd ? 1'b0 : (wr ? 1'b1 : m_en);
    req_n = ack ? 1'b0 : (t_rise ? m_en : m_req);
    sy_n  = ack ? 1'b0 : (f_rise ? m_req : m_sy);
    m_en = en_n; m_req = req_n; m_sy = sy_n;
    m_t = {m_t[1:0], tick};
    m_f = {m_f[1:0], fetch};
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq_no actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    #1;
    if (rst_n) model_edge();
    @(negedge clk);
    check(tag, irq_n, exp_irq_n(m_f[1], m_sy, m_req));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic pulse_tick(input string tag);
    tick = 1'b1; idle(4, tag);
    tick = 1'b0; idle(4, tag);
  endtask

  task automatic pulse_fetch(input string tag);
    fetch = 1'b1; idle(5, tag);
    fetch = 1'b0; idle(4, tag);
  endtask

  task automatic strobe(input logic w, input logic r, input string tag);
    wr = w; rd = r; step(tag);
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 in reset", irq_n, 1'b1);
    rst_n = 1'b1;
    idle(3, "R1 after reset");
    fetch = 1'b1; idle(4, "R1 fetch only"); fetch = 1'b0; idle(3, "R1");

    // R5 tick while disabled: request stays empty
    pulse_tick("R5 disabled tick");
    pulse_fetch("R5 disabled fetch");

    // R2 enable then tick, fetch drives output low (R7)
    strobe(1'b1, 1'b0, "R2 set");
    pulse_tick("R2 armed tick");
    fetch = 1'b1; idle(2, "R9 latency");
    step("R9 edge seen");
    idle(3, "R7 low while fetch high");
    check("R7 low", irq_n, 1'b0);
    fetch = 1'b0; idle(3, "R7 release");
    check("R7 high after fetch low", irq_n, 1'b1);
    // R6 second fetch edge reloads request still held
    pulse_fetch("R6 refetch");

    // R8 acknowledge clears
    ack = 1'b1; step("R8 ack"); ack = 1'b0;
    pulse_fetch("R8 after ack");

    // R3 read clears, tick resamples 0
    strobe(1'b0, 1'b1, "R3 clear");
    pulse_tick("R3 tick after clear");
    pulse_fetch("R3 fetch after clear");

    // R4 both strobes -> cleared
    strobe(1'b1, 1'b0, "R4 set");
    strobe(1'b1, 1'b1, "R4 both");
    pulse_tick("R4 tick");
    pulse_fetch("R4 fetch");

    // R8 ack coinciding with tick edge
    strobe(1'b1, 1'b0, "R8 arm");
    tick = 1'b1; step("R8 prio");
    ack = 1'b1; idle(2, "R8 prio ack"); ack = 1'b0;
    idle(2, "R8 prio"); tick = 1'b0; idle(3, "R8 prio");
    pulse_fetch("R8 prio dropped");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 11) == 0) tick = ~tick;
      if ($urandom_range(0, 4) == 0)  fetch = ~fetch;
      ack = ($urandom_range(0, 39) == 0);
      wr  = ($urandom_range(0, 15) == 0);
      rd  = ($urandom_range(0, 47) == 0);
      step("R7 random");
    end
    ack = 1'b0; wr = 1'b0; rd = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule